// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block is the host-facing register file for a bank of four 12-bit digital-to-analog converters. The host writes a 12-bit code per channel and one shared range word that holds a polarity bit and a gain bit for every channel. Both kinds of value land first in shadow registers. Two read side-effect strobes move them into the active registers that drive the converter pins. A read of one offset commits the range word. A read of another offset commits all four codes in the same cycle, so every channel changes together.

A control word enables the bank and selects buffered or immediate update. With immediate update, a code write also reaches that channel's active output at once. While the bank is disabled, every active output reads zero and both commit strobes are ignored. The shadow registers keep their contents. Reset is synchronous and active low. It clears the control word, every shadow register and every active register.

Top module: `quad_dac_regbank`

## Requirements
- R1: After reset, every bit of `dac_code`, `dac_bipolar` and `dac_gain` is 0, and a commit read (offset 0x02 or 0x12) before any control write leaves them at 0.
- R2: With control bits {enable, buffered} = 2'b11, a write to offset 0x14 + 2·n (n = 0..3) changes only channel n's shadow code. The active outputs stay unchanged until a commit read.
- R3: With the bank enabled, a read of offset 0x02 copies all four shadow codes into `dac_code` on the same clock edge. Channel n occupies bits [12·n+11 : 12·n].
- R4: A write to offset 0x12 loads the shadow range word. With the bank enabled, a read of 0x12 makes it active. Channel n's polarity is write-data bit 7−n and drives `dac_bipolar[n]` (1 = bipolar). Its gain is bit 11−n and drives `dac_gain[n]`.
- R5: With control = 2'b10 (enabled, immediate), a code write to channel n appears on that channel's output one clock edge later. The other channels keep their values.
- R6: While control bit 1 (enable) is 0, all outputs are 0 and commit reads have no effect. Shadow contents survive, so a commit after re-enabling shows the earlier shadow values.
- R7: Bits 15:12 of a code write are ignored. Writing 0xF333 yields code 0x333.
- R8: The two commits are independent: a read of 0x02 does not change the range outputs, and a read of 0x12 does not change the codes. A read of any data offset (0x14..0x1A) has no effect.
- R9: A reset in mid-operation clears the outputs, the control word (enable = buffered = 0) and all shadow registers. After re-enabling, commits of both kinds give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects only |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| dac_code | output | 48 | Active 12-bit codes, channel n at [12n+11:12n] |
| dac_bipolar | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain | output | 4 | Active gain select per channel |

## Verification
The assertions check four things on every cycle. Outputs stay at zero whenever the enable bit, as seen from control writes, is clear. Codes hold still unless a control write, a code write or a 0x02 read occurs. Range outputs hold still unless a control write or a 0x12 read occurs. In immediate mode, a code write reaches its channel one edge later.

Some properties need a known history, so only the directed scenarios can show them. These are:
- the exact reversed bit placement of polarity and gain;
- the masking of the upper code bits;
- the survival of shadow contents through a disable;
- the clearing of shadow state by a reset in mid-operation.

// File: rtl/quad_dac_pkg.sv
// Shared constants and helpers for the four-channel DAC register bank.
// Assumes byte offsets on the bus and 16-bit write data.
package quad_dac_pkg;
    localparam int NCH     = 4;
    localparam int DW      = 12;
    localparam int BW      = 16;
    localparam int AW      = 8;

    localparam logic [AW-1:0] OFS_CTRL   = 8'h02;  // control write, code commit read
    localparam logic [AW-1:0] OFS_RANGE  = 8'h12;  // range write, range commit read
    localparam logic [AW-1:0] OFS_CODE0  = 8'h14;  // channel n at OFS_CODE0 + 2n

    localparam int CTRL_EN_BIT  = 1;
    localparam int CTRL_BUF_BIT = 0;
    localparam int POL_TOP      = 7;   // channel n polarity at POL_TOP - n
    localparam int GAIN_TOP     = 11;  // channel n gain at GAIN_TOP - n

    // Byte offset of channel n's code register.
    function automatic logic [AW-1:0] code_ofs(input int n);
        return OFS_CODE0 + AW'(2 * n);
    endfunction

    // True when the offset selects any channel code register.
    function automatic logic is_code_ofs(input logic [AW-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int n = 0; n < NCH; n++) begin
            if (a == code_ofs(n)) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/quad_dac_decode.sv
// Address decode: turns single-cycle bus strobes into register write
// enables and commit pulses. Purely combinational; assumes at most one
// access per cycle on the shared address.
module quad_dac_decode
    import quad_dac_pkg::*;
(
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    output logic           ctrl_we,
    output logic           range_we,
    output logic           range_commit,
    output logic           code_commit,
    output logic [NCH-1:0] code_we
);
    // Control and range offsets decode.
    always_comb begin
        ctrl_we      = bus_wr && (bus_addr == OFS_CTRL);
        range_we     = bus_wr && (bus_addr == OFS_RANGE);
        range_commit = bus_rd && (bus_addr == OFS_RANGE);
        code_commit  = bus_rd && (bus_addr == OFS_CTRL);
    end

    // One write enable per channel code register.
    for (genvar n = 0; n < NCH; n++) begin : g_code_dec
        assign code_we[n] = bus_wr && (bus_addr == code_ofs(n));
    end
endmodule

// File: rtl/quad_dac_ctrl.sv
// Control word: bank enable and buffered-update select.
// Cleared by synchronous active-low reset.
module quad_dac_ctrl
    import quad_dac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [BW-1:0] wdata,
    output logic          bank_en,
    output logic          buffered
);
    // Capture the two control bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en  <= 1'b0;
            buffered <= 1'b0;
        end else if (ctrl_we) begin
            bank_en  <= wdata[CTRL_EN_BIT];
            buffered <= wdata[CTRL_BUF_BIT];
        end
    end
endmodule

// File: rtl/quad_dac_range.sv
// Shadow and active range word. Channel n's polarity and gain come
// from reversed bit positions. Only the commit strobe moves the shadow
// to active. Assumes the active copy is forced to zero while disabled.
module quad_dac_range
    import quad_dac_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bank_en,
    input  logic           range_we,
    input  logic           range_commit,
    input  logic [BW-1:0]  wdata,
    output logic [NCH-1:0] bipolar,
    output logic [NCH-1:0] gain
);
    logic [NCH-1:0] sh_pol, sh_gain, act_pol, act_gain;
    logic [NCH-1:0] in_pol, in_gain;

    // Pick each channel's bits out of the reversed field layout.
    for (genvar n = 0; n < NCH; n++) begin : g_pick
        assign in_pol[n]  = wdata[POL_TOP - n];
        assign in_gain[n] = wdata[GAIN_TOP - n];
    end

    // Shadow range word, loaded by a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pol  <= '0;
            sh_gain <= '0;
        end else if (range_we) begin
            sh_pol  <= in_pol;
            sh_gain <= in_gain;
        end
    end

    // Active range word: cleared while disabled, else loaded on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || !bank_en) begin
            act_pol  <= '0;
            act_gain <= '0;
        end else if (range_commit) begin
            act_pol  <= sh_pol;
            act_gain <= sh_gain;
        end
    end

    assign bipolar = bank_en ? act_pol  : '0;
    assign gain    = bank_en ? act_gain : '0;
endmodule

// File: rtl/quad_dac_chan.sv
// One channel: a shadow code register and an active code register.
// In immediate mode a write goes straight through, and it takes
// priority over a simultaneous bulk commit. Upper write bits are dropped.
module quad_dac_chan
    import quad_dac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_en,
    input  logic          buffered,
    input  logic          code_we,
    input  logic          code_commit,
    input  logic [DW-1:0] wcode,
    output logic [DW-1:0] code
);
    logic [DW-1:0] sh_code, act_code;

    // Shadow code, written by the host in any mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_code <= '0;
        else if (code_we) sh_code <= wcode;
    end

    // Active code: cleared while disabled, immediate write, or bulk commit.
    always_ff @(posedge clk) begin
        if (!rst_n || !bank_en)         act_code <= '0;
        else if (code_we && !buffered)  act_code <= wcode;
        else if (code_commit)           act_code <= sh_code;
    end

    assign code = bank_en ? act_code : '0;
endmodule

// File: rtl/quad_dac_regbank.sv
// Top of the four-channel double-buffered DAC register bank. Writes
// load shadow registers. A read of the control offset commits all codes,
// and a read of the range offset commits polarity and gain.
// Assumes single-cycle strobes and a synchronous active-low reset.
module quad_dac_regbank
    import quad_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    dac_bipolar,
    output logic [NCH-1:0]    dac_gain
);
    logic           ctrl_we, range_we, range_commit, code_commit;
    logic [NCH-1:0] code_we;
    logic           bank_en, buffered;
    logic           unused_wdata;

    assign unused_wdata = ^bus_wdata[BW-1:DW];

    quad_dac_decode u_dec (
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .ctrl_we      (ctrl_we),
        .range_we     (range_we),
        .range_commit (range_commit),
        .code_commit  (code_commit),
        .code_we      (code_we)
    );

    quad_dac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .wdata    (bus_wdata),
        .bank_en  (bank_en),
        .buffered (buffered)
    );

    quad_dac_range u_range (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_en      (bank_en),
        .range_we     (range_we),
        .range_commit (range_commit),
        .wdata        (bus_wdata),
        .bipolar      (dac_bipolar),
        .gain         (dac_gain)
    );

    // One channel slice per converter.
    for (genvar n = 0; n < NCH; n++) begin : g_chan
        quad_dac_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .bank_en     (bank_en),
            .buffered    (buffered),
            .code_we     (code_we[n]),
            .code_commit (code_commit),
            .wcode       (bus_wdata[DW-1:0]),
            .code        (dac_code[n*DW +: DW])
        );
    end
endmodule

// File: rtl/quad_dac_regbank_chk.sv
// Checker for the DAC register bank. It sees only the top-level ports
// and tracks the control word from observed control writes.
module quad_dac_regbank_chk
    import quad_dac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input logic [BW-1:0]     bus_wdata,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    dac_bipolar,
    input logic [NCH-1:0]    dac_gain
);
    logic obs_en, obs_buf;

    // Track enable and buffered bits as the host writes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obs_en  <= 1'b0;
            obs_buf <= 1'b0;
        end else if (bus_wr && bus_addr == OFS_CTRL) begin
            obs_en  <= bus_wdata[CTRL_EN_BIT];
            obs_buf <= bus_wdata[CTRL_BUF_BIT];
        end
    end

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dac_code == '0 && dac_bipolar == '0 && dac_gain == '0));

    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !obs_en |-> (dac_code == '0 && dac_bipolar == '0 && dac_gain == '0));

    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_en && !(bus_wr && (bus_addr == OFS_CTRL || is_code_ofs(bus_addr)))
                && !(bus_rd && bus_addr == OFS_CTRL))
        |=> $stable(dac_code));

    a_r4_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_en && !(bus_wr && bus_addr == OFS_CTRL) && !(bus_rd && bus_addr == OFS_RANGE))
        |=> ($stable(dac_bipolar) && $stable(dac_gain)));

    for (genvar n = 0; n < NCH; n++) begin : g_imm
        a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
            (obs_en && !obs_buf && bus_wr && bus_addr == code_ofs(n))
            |=> (dac_code[n*DW +: DW] == $past(bus_wdata[DW-1:0])));
    end
endmodule

bind quad_dac_regbank quad_dac_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .dac_code    (dac_code),
    .dac_bipolar (dac_bipolar),
    .dac_gain    (dac_gain)
);

// File: tb/tb_quad_dac_regbank.sv
module tb_quad_dac_regbank;
    import quad_dac_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [BW-1:0]     bus_wdata = '0;
    logic [NCH*DW-1:0] dac_code;
    logic [NCH-1:0]    dac_bipolar;
    logic [NCH-1:0]    dac_gain;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    quad_dac_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dac_code(dac_code), .dac_bipolar(dac_bipolar), .dac_gain(dac_gain)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [NCH*DW-1:0] codes(input logic [DW-1:0] c0, c1, c2, c3);
        return {c3, c2, c1, c0};
    endfunction

    task automatic t_reset;
        check("R1 code after reset", 64'(dac_code), 64'h0);
        check("R1 range after reset", 64'({dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_CTRL);
        rd(OFS_RANGE);
        check("R1 commit before control write", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
    endtask

    task automatic t_buffered;
        wr(OFS_CTRL, 16'h0003);
        wr(8'h14, 16'h0111);
        wr(8'h16, 16'h0222);
        wr(8'h18, 16'hF333);
        wr(8'h1A, 16'h0444);
        check("R2 shadow only", 64'(dac_code), 64'h0);
        rd(OFS_CTRL);
        check("R3 bulk commit", 64'(dac_code), 64'(codes(12'h111, 12'h222, 12'h333, 12'h444)));
        check("R7 upper bits dropped", 64'(dac_code[2*DW +: DW]), 64'h333);
    endtask

    task automatic t_range;
        wr(OFS_RANGE, 16'h0A50);
        check("R4 range shadow only", 64'({dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_CTRL);
        check("R8 code commit leaves range", 64'({dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_RANGE);
        check("R4 polarity reversed", 64'(dac_bipolar), 64'hA);
        check("R4 gain reversed", 64'(dac_gain), 64'h5);
        wr(8'h16, 16'h0555);
        rd(OFS_RANGE);
        check("R8 range commit leaves codes", 64'(dac_code),
              64'(codes(12'h111, 12'h222, 12'h333, 12'h444)));
    endtask

    task automatic t_data_reads;
        rd(8'h14);
        rd(8'h16);
        rd(8'h1A);
        check("R8 data offset read ignored", 64'(dac_code),
              64'(codes(12'h111, 12'h222, 12'h333, 12'h444)));
    endtask

    task automatic t_immediate;
        wr(OFS_CTRL, 16'h0002);
        wr(8'h1A, 16'h0ABC);
        check("R5 immediate write", 64'(dac_code),
              64'(codes(12'h111, 12'h222, 12'h333, 12'hABC)));
        check("R5 range untouched", 64'({dac_bipolar, dac_gain}), 64'hA5);
    endtask

    task automatic t_disable;
        wr(OFS_CTRL, 16'h0001);
        check("R6 disabled zero", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_CTRL);
        rd(OFS_RANGE);
        check("R6 commits ignored", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
        wr(OFS_CTRL, 16'h0003);
        check("R6 re-enable still zero", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_CTRL);
        rd(OFS_RANGE);
        check("R6 shadow kept codes", 64'(dac_code),
              64'(codes(12'h111, 12'h555, 12'h333, 12'hABC)));
        check("R6 shadow kept range", 64'({dac_bipolar, dac_gain}), 64'hA5);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R9 outputs cleared", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
        rd(OFS_CTRL);
        rd(OFS_RANGE);
        check("R9 control cleared", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
        wr(OFS_CTRL, 16'h0003);
        rd(OFS_CTRL);
        rd(OFS_RANGE);
        check("R9 shadows cleared", 64'({dac_code, dac_bipolar, dac_gain}), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_buffered();
        t_range();
        t_data_reads();
        t_immediate();
        t_disable();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule